// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block produces the interrupt status of a serial peripheral controller. It watches the fill levels of the transmit and receive FIFOs and their push and pop strobes. From them it derives five interrupt sources. Two sources are level conditions measured against programmable thresholds. Three are error events that stay latched until software clears them.

Software reaches the block through a small register port with eight word addresses. Through that port it sets the two thresholds and the mask. It reads the raw status, the masked status and both fill levels. A read of the clear address clears the latched errors. A single interrupt output is the registered OR of the masked status bits.

The FIFOs and the shift engine sit outside this block. They report their occupancy as counts and signal data movement as single-cycle strobes.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Status bits are laid out as bit0 transmit-low, bit1 transmit overflow, bit2 receive underflow, bit3 receive overflow and bit4 receive-high. The raw status reads at address 3 with zero in the upper bits.
- R2: The masked status reads at address 4 and equals the raw status ANDed with the mask. The mask is at address 2, bits 4:0. With a zero mask the interrupt output stays low whatever the raw status is.
- R3: The transmit-low bit is 1 exactly while the transmit level is less than or equal to the transmit threshold (address 0).
- R4: The receive-high bit is 1 exactly while the receive level is strictly greater than the receive threshold (address 1).
- R5: A transmit push while the transmit level equals DEPTH sets bit1. A receive push while the receive level equals DEPTH sets bit3. A receive pop while the receive level is 0 sets bit2. Each flag is visible in the cycle after the event.
- R6: A threshold write with a value of DEPTH or more is discarded, and a read of that threshold still returns the previous value. Values below DEPTH are stored.
- R7: The transmit level reads at address 5 and the receive level at address 6.
- R8: Error flags hold until a read of address 7. That read returns the error bits (positions 1 to 3) as they stood before the read, then clears them. An error event in the same cycle as the clear leaves its flag set.
- R9: The threshold bits are not latched: each falls as soon as its level condition stops holding.
- R10: The interrupt output is 1 one cycle after any masked status bit is 1, and 0 one cycle after none is. It never changes in the same cycle as its cause.
- R11: After a synchronous reset, both thresholds and the mask are 0, all error flags are 0 and the interrupt output is 0.
- R12: Read data appears on the read data port, with the valid output high, in the cycle after the read strobe. Writes to addresses 3 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_push | input | 1 | Entry written into the transmit FIFO |
| rx_push | input | 1 | Frame arriving into the receive FIFO |
| rx_pop | input | 1 | Entry read from the receive FIFO |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to reach is a clear-on-read that falls in the same clock edge as a fresh error event. That case decides whether the set path or the clear path wins the flag. The stimulus holds the modelled receive FIFO empty, then raises the clear read and a receive pop on the same falling edge. It expects the read to return the older error bits, and a later raw read to still show the underflow. The stimulus also drives the transmit and receive FIFO models to their full count before pushing. It returns them below their thresholds afterwards, to show that the latched and level-following bits separate.

// File: rtl/izc_pkg.sv
package izc_pkg;

    // Register word addresses
    typedef enum logic [2:0] {
        A_TXTHR   = 3'd0,
        A_RXTHR   = 3'd1,
        A_MASK    = 3'd2,
        A_RAW     = 3'd3,
        A_MSKSTS  = 3'd4,
        A_TXLVL   = 3'd5,
        A_RXLVL   = 3'd6,
        A_CLR     = 3'd7
    } izc_addr_e;

    localparam int NSRC = 5;
    localparam int NERR = 3;

    // Status vector, MSB first: bit4 .. bit0
    typedef struct packed {
        logic rx_high;
        logic rx_ovf;
        logic rx_unf;
        logic tx_ovf;
        logic tx_low;
    } izc_src_t;

    // Error sources in the order of status bits 1..3
    typedef struct packed {
        logic rx_ovf;
        logic rx_unf;
        logic tx_ovf;
    } izc_err_t;

    function automatic logic below_depth(input logic [31:0] value, input int depth);
        return value < 32'(depth);
    endfunction

endpackage

// File: rtl/izc_cfg_regs.sv
module izc_cfg_regs
    import izc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LVL_W-1:0]  tx_thr,
    output logic [LVL_W-1:0]  rx_thr,
    output logic [NSRC-1:0]   mask
);
    logic [LVL_W-1:0] thr_q [2];
    logic             data_ok;

    assign data_ok = below_depth(32'(wr_data), DEPTH);

    // One threshold register per direction; out-of-range values are dropped
    for (genvar g = 0; g < 2; g++) begin : g_thr
        localparam logic [2:0] SEL = (g == 0) ? A_TXTHR : A_RXTHR;
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q[g] <= '0;
            end else if (wr_en && wr_addr == SEL && data_ok) begin
                thr_q[g] <= wr_data[LVL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (wr_en && wr_addr == A_MASK) begin
            mask <= wr_data[NSRC-1:0];
        end
    end

    assign tx_thr = thr_q[0];
    assign rx_thr = thr_q[1];

endmodule

// File: rtl/izc_level_cmp.sv
module izc_level_cmp #(
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    output logic             tx_low,
    output logic             rx_high
);
    // Pure level compare: no state, so bits follow the counts directly
    always_comb begin
        tx_low  = (tx_level <= tx_thr);
        rx_high = (rx_level >  rx_thr);
    end
endmodule

// File: rtl/izc_err_flags.sv
module izc_err_flags
    import izc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             tx_push,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             clr,
    output izc_err_t         flags
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    izc_err_t        evt;
    logic [NERR-1:0] evt_v;
    logic [NERR-1:0] flag_q;

    always_comb begin
        evt.tx_ovf = tx_push && (tx_level == FULL);
        evt.rx_ovf = rx_push && (rx_level == FULL);
        evt.rx_unf = rx_pop  && (rx_level == '0);
    end

    assign evt_v = evt;

    // Sticky flags: a new event has priority over the clear
    for (genvar i = 0; i < NERR; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (evt_v[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flag_q;

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import izc_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_push,
    input  logic              rx_push,
    input  logic              rx_pop,
    output logic              irq
);
    logic [LVL_W-1:0]  tx_thr;
    logic [LVL_W-1:0]  rx_thr;
    logic [NSRC-1:0]   mask_q;
    logic              tx_low;
    logic              rx_high;
    logic              clr_rd;
    izc_err_t          err;
    izc_src_t          raw;
    logic [NSRC-1:0]   raw_vec;
    logic [NSRC-1:0]   msk_vec;
    logic [DATA_W-1:0] rd_mux;

    assign clr_rd = reg_rd && (reg_addr == A_CLR);

    izc_cfg_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask_q)
    );

    izc_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr),
        .rx_thr(rx_thr), .tx_low(tx_low), .rx_high(rx_high)
    );

    izc_err_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_err (
        .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
        .clr(clr_rd), .flags(err)
    );

    always_comb begin
        raw.tx_low  = tx_low;
        raw.tx_ovf  = err.tx_ovf;
        raw.rx_unf  = err.rx_unf;
        raw.rx_ovf  = err.rx_ovf;
        raw.rx_high = rx_high;
    end

    assign raw_vec = raw;
    assign msk_vec = raw_vec & mask_q;

    always_comb begin
        case (izc_addr_e'(reg_addr))
            A_TXTHR:  rd_mux = DATA_W'(tx_thr);
            A_RXTHR:  rd_mux = DATA_W'(rx_thr);
            A_MASK:   rd_mux = DATA_W'(mask_q);
            A_RAW:    rd_mux = DATA_W'(raw_vec);
            A_MSKSTS: rd_mux = DATA_W'(msk_vec);
            A_TXLVL:  rd_mux = DATA_W'(tx_level);
            A_RXLVL:  rd_mux = DATA_W'(rx_level);
            default:  rd_mux = DATA_W'({err, 1'b0});
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
            irq        <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                reg_rdata <= rd_mux;
            end
            irq <= |msk_vec;
        end
    end

endmodule

// File: rtl/izc_checker.sv
module izc_checker
    import izc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             tx_push,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             clr_rd,
    input logic [NSRC-1:0]  raw,
    input logic [NSRC-1:0]  mask,
    input logic [LVL_W-1:0] tx_thr,
    input logic [LVL_W-1:0] rx_thr,
    input logic             irq
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    p_tx_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_level == FULL) |=> raw[1]);

    p_rx_unf_set_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_level == '0) |=> raw[2]);

    p_rx_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_level == FULL) |=> raw[3]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (raw[1] && !clr_rd) |=> raw[1]);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_rd && !tx_push && !rx_push && !rx_pop) |=> (raw[3:1] == 3'b000));

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (rst)
        (|(raw & mask)) |=> irq);

    p_irq_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !(|(raw & mask)) |=> !irq);

    p_thr_range_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_thr < FULL) && (rx_thr < FULL));

endmodule

bind fifo_irq_ctrl izc_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .clr_rd(clr_rd), .raw(raw_vec), .mask(mask_q),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .irq(irq)
);

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              reg_rvalid;
    logic [LVL_W-1:0]  tx_level = '0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic              tx_push = 1'b0;
    logic              rx_push = 1'b0;
    logic              rx_pop = 1'b0;
    logic              irq;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    always #2 clk = ~clk;

    fifo_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop), .irq(irq)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every returned read
    always @(negedge clk) begin
        if (!rst && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected read data", 16'h1, 16'h0);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: issues a read and queues its expected value
    task automatic rd(input logic [2:0] a, input logic [DATA_W-1:0] e,
                      input string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_tx(input int v);
        @(negedge clk);
        tx_level = LVL_W'(v);
    endtask

    task automatic set_rx(input int v);
        @(negedge clk);
        rx_level = LVL_W'(v);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tx_push = 1'b1;
            1: rx_push = 1'b1;
            default: rx_pop = 1'b1;
        endcase
        @(negedge clk);
        tx_push = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 irq after reset", 16'(irq), 16'h0);
        rd(3'd0, 16'h0, "R11 tx threshold reset");
        rd(3'd1, 16'h0, "R11 rx threshold reset");
        rd(3'd2, 16'h0, "R11 mask reset");
        rd(3'd3, 16'h01, "R1 raw status after reset");
        rd(3'd4, 16'h00, "R2 masked status after reset");

        // Threshold range checks (R6)
        wr(3'd0, 16'd3); rd(3'd0, 16'd3, "R6 tx threshold stored");
        wr(3'd0, 16'd8); rd(3'd0, 16'd3, "R6 tx write at depth dropped");
        wr(3'd0, 16'd7); rd(3'd0, 16'd7, "R6 tx depth-1 stored");
        wr(3'd0, 16'd3);
        wr(3'd1, 16'd2); wr(3'd1, 16'h0100);
        rd(3'd1, 16'd2, "R6 rx large write dropped");
        wr(3'd4, 16'h1F); rd(3'd2, 16'h0, "R12 write to status ignored");

        // Level thresholds (R3, R4, R9)
        set_tx(4); rd(3'd3, 16'h00, "R3 tx above threshold");
        set_tx(3); rd(3'd3, 16'h01, "R3 tx at threshold");
        set_rx(3); rd(3'd3, 16'h11, "R4 rx above threshold");
        set_rx(2); rd(3'd3, 16'h01, "R9 rx bit not latched");
        rd(3'd5, 16'd3, "R7 tx level");
        rd(3'd6, 16'd2, "R7 rx level");

        // Error events (R5, R8)
        set_tx(8); pulse(0);
        rd(3'd3, 16'h02, "R5 tx overflow");
        set_tx(3); rd(3'd3, 16'h03, "R8 tx overflow sticky");
        set_rx(0); pulse(2);
        rd(3'd3, 16'h07, "R5 rx underflow");
        set_rx(8); pulse(1);
        rd(3'd3, 16'h1F, "R5 rx overflow");

        // Mask and interrupt (R2, R10)
        wr(3'd2, 16'h0A);
        rd(3'd4, 16'h0A, "R2 masked status");
        check("R10 irq with masked bits", 16'(irq), 16'h1);
        wr(3'd2, 16'h00);
        @(negedge clk);
        check("R2 zero mask silences irq", 16'(irq), 16'h0);

        // Clear on read (R8)
        rd(3'd7, 16'h0E, "R8 clear returns error bits");
        rd(3'd3, 16'h11, "R8 errors cleared");

        // Interrupt register stage (R10)
        wr(3'd2, 16'h10);
        @(negedge clk);
        check("R10 irq from rx high", 16'(irq), 16'h1);
        rx_level = LVL_W'(1);
        #1 check("R10 irq not combinational", 16'(irq), 16'h1);
        @(negedge clk);
        check("R10 irq drops next cycle", 16'(irq), 16'h0);

        // Clear and event in the same cycle (R8)
        set_rx(0);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd7; rx_pop = 1'b1;
        exp_q.push_back(16'h00); tag_q.push_back("R8 clear read value");
        @(negedge clk);
        reg_rd = 1'b0; rx_pop = 1'b0;
        rd(3'd3, 16'h05, "R8 event wins over clear");

        repeat (3) @(negedge clk);
        check("R12 all reads returned", 16'(exp_q.size()), 16'h0);
        finish_run();
    end
endmodule